// File: doc/BRIEF.md
# Multiphase PWM Phase Sequencer

This block drives two, three or four interleaved pulse-width-modulated phase outputs for a multiphase buck converter. It runs a free-running period counter. When power comes up it waits for both the supply-good and the external enable input. At the first clock edge where both are high, it reads a strap input for each phase pin. A phase whose strap reads high is unused. From the populated set the block works out the active phase count N. It then spaces the phases evenly, each by PERIOD/N counts.

Each active phase takes a shared duty command. The block subtracts a per-phase trim from it, so a channel carrying more than its share of current gets a shorter pulse. The result is limited to about two thirds of the period. Each phase latches its width only at the start of its own period, so a command change never cuts a pulse short. Every output has a separate enable, so a pin can be high, low or undriven. All pins stay undriven until detection succeeds. An illegal strap pattern locks the block into a quiet error state. A global inhibit input pulls every driven output low.

Top module: `mpwm_seq`

## Requirements
- R1: After a synchronous reset, `pwm_oe`, `pwm_out`, `ph_ready` and `cfg_err` are all 0.
- R2: Detection happens at the first clock edge where `supply_ok` and `ext_en` are both 1. Until then `ph_ready` stays 0 and every output stays undriven, even if only one of the two inputs is high.
- R3: A strap bit of 1 marks its phase unused. The populated mask is the inverted strap. The masks 0011, 0111 and 1111 are legal and give `ph_count` 2, 3 and 4. `ph_ready` rises at the detection edge, and the populated bits of `pwm_oe` rise one edge later.
- R4: Any other populated mask sets `cfg_err`: phase 1 missing, a gap, or fewer than two phases. `pwm_oe` and `pwm_out` then stay 0 until reset.
- R5: The strap is read only once. Later strap changes leave `pwm_oe` and `ph_count` unchanged.
- R6: Phase k (k = 0..N-1, bit k of `pwm_out`) rises k*PERIOD/N clock cycles after phase 0.
- R7: Each active phase is high for W = min(max(cmd - trim_k, 0), MAXON) consecutive cycles in every period. Trim_k is bits [4k+3:4k] of `duty_trim`.
- R8: MAXON = floor(PERIOD*2/3), which is 32 counts for the default PERIOD of 48. A larger command is clamped to MAXON.
- R9: A phase loads its width only at the start of its own period. A command change during a pulse leaves that pulse's width as it was.
- R10: While `inhibit` is 1, `pwm_out` is 0 from the next clock edge on and `pwm_oe` is unchanged.
- R11: Unused phases keep `pwm_oe` and `pwm_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good indication |
| ext_en | input | 1 | External enable threshold indication |
| ph_strap | input | 4 | Per-phase strap sense, 1 = unused |
| duty_cmd | input | 6 | Shared duty command in counts |
| duty_trim | input | 16 | Four 4-bit per-phase width reductions |
| inhibit | input | 1 | Global inhibit, forces outputs low |
| pwm_out | output | 4 | Phase drive levels |
| pwm_oe | output | 4 | Phase drive enables, 0 = high impedance |
| ph_ready | output | 1 | Detection succeeded, phases running |
| cfg_err | output | 1 | Illegal strap pattern detected |
| ph_count | output | 3 | Detected active phase count |

## Verification
The assertions check several rules on every cycle. No drive is enabled before detection, and the error state stays quiet and sticky. A pulse never runs longer than the on-time limit. No output is high without its enable. The latched width and mask change only at their permitted moments. Inhibit takes effect one edge after it is raised. Only the bench scenarios can show the things that span a full period: the exact pulse widths after trim and clamp, the phase lag for each count N, the width held across a mid-pulse command change, and the decoding of the strap patterns.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  typedef enum logic [1:0] {
    DET_WAIT = 2'd0,
    DET_RUN  = 2'd1,
    DET_ERR  = 2'd2
  } det_state_t;
endpackage

// File: rtl/mpwm_detect.sv
module mpwm_detect #(
  parameter int MAX_PH = 4,
  parameter int PERIOD = 48,
  parameter int CW     = 6,
  parameter int NW     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 supply_ok,
  input  logic                 ext_en,
  input  logic [MAX_PH-1:0]    strap,
  output logic                 run,
  output logic                 err,
  output logic [MAX_PH-1:0]    mask,
  output logic [NW-1:0]        nph,
  output logic [MAX_PH*CW-1:0] offs
);
  import mpwm_pkg::*;

  det_state_t            state_q;
  logic [MAX_PH-1:0]     mask_q;
  logic [NW-1:0]         nph_q;
  logic [MAX_PH*CW-1:0]  offs_q;

  logic [MAX_PH-1:0]     cand;
  logic [MAX_PH:0]       cand_inc;
  logic                  contiguous;
  logic                  legal;
  int                    cand_cnt;
  logic [MAX_PH*CW-1:0]  cand_offs;

  always_comb begin
    cand       = ~strap;
    cand_inc   = {1'b0, cand} + {{MAX_PH{1'b0}}, 1'b1};
    contiguous = (({1'b0, cand} & cand_inc) == '0);
    cand_cnt   = 0;
    for (int k = 0; k < MAX_PH; k++) cand_cnt += int'(cand[k]);
    legal = contiguous && (cand_cnt >= 2);
    for (int k = 0; k < MAX_PH; k++) begin
      cand_offs[k*CW +: CW] = CW'((k * PERIOD) / ((cand_cnt == 0) ? 1 : cand_cnt));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DET_WAIT;
      mask_q  <= '0;
      nph_q   <= '0;
      offs_q  <= '0;
    end else if (state_q == DET_WAIT && supply_ok && ext_en) begin
      if (legal) begin
        state_q <= DET_RUN;
        mask_q  <= cand;
        nph_q   <= NW'(cand_cnt);
        offs_q  <= cand_offs;
      end else begin
        state_q <= DET_ERR;
      end
    end
  end

  assign run  = (state_q == DET_RUN);
  assign err  = (state_q == DET_ERR);
  assign mask = mask_q;
  assign nph  = nph_q;
  assign offs = offs_q;

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    run |=> ($stable(mask_q) && $stable(nph_q)));                 // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err);                                                 // R4
  AST_RUN_COUNT: assert property (@(posedge clk) disable iff (rst)
    run |-> (nph_q >= NW'(2) && mask_q[0]));                      // R3
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
  parameter int PERIOD = 48,
  parameter int CW     = 6,
  parameter int TW     = 4,
  parameter int MAXON  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          active,
  input  logic          inhibit,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] offset,
  input  logic [CW-1:0] cmd,
  input  logic [TW-1:0] trim,
  output logic          pwm,
  output logic          oe
);
  logic [CW-1:0] pcnt;
  logic [CW-1:0] want;
  logic [CW-1:0] cur;
  logic [CW-1:0] duty_q;
  logic [CW-1:0] trim_x;
  logic          pwm_q;
  logic          oe_q;

  always_comb begin
    if (cnt >= offset) pcnt = cnt - offset;
    else               pcnt = CW'(cnt + CW'(PERIOD) - offset);
    trim_x = CW'(trim);
    want   = (cmd > trim_x) ? (cmd - trim_x) : '0;
    if (want > CW'(MAXON)) want = CW'(MAXON);
    cur = (pcnt == '0) ? want : duty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      pwm_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (pcnt == '0) duty_q <= want;
      oe_q  <= run && active;
      pwm_q <= run && active && !inhibit && (pcnt < cur);
    end
  end

  assign pwm = pwm_q;
  assign oe  = oe_q;

  logic [CW:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)        hi_run <= '0;
    else if (pwm_q) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  AST_MAX_ON: assert property (@(posedge clk) disable iff (rst)
    hi_run <= (CW+1)'(MAXON));                                    // R8
  AST_INHIBIT_LOW: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> !pwm_q);                                          // R10
  AST_PWM_HAS_OE: assert property (@(posedge clk) disable iff (rst)
    pwm_q |-> oe_q);                                              // R11
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pcnt != '0) |=> $stable(duty_q));                            // R9
endmodule

// File: rtl/mpwm_seq.sv
module mpwm_seq #(
  parameter int MAX_PH    = 4,
  parameter int PERIOD    = 48,
  parameter int TRIM_W    = 4,
  parameter int MAXON_NUM = 2,
  parameter int MAXON_DEN = 3,
  localparam int CW    = $clog2(PERIOD + 1),
  localparam int NW    = $clog2(MAX_PH + 1),
  localparam int MAXON = (PERIOD * MAXON_NUM) / MAXON_DEN
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     supply_ok,
  input  logic                     ext_en,
  input  logic [MAX_PH-1:0]        ph_strap,
  input  logic [CW-1:0]            duty_cmd,
  input  logic [MAX_PH*TRIM_W-1:0] duty_trim,
  input  logic                     inhibit,
  output logic [MAX_PH-1:0]        pwm_out,
  output logic [MAX_PH-1:0]        pwm_oe,
  output logic                     ph_ready,
  output logic                     cfg_err,
  output logic [NW-1:0]            ph_count
);
  logic [CW-1:0]        cnt_q;
  logic                 run;
  logic                 err;
  logic [MAX_PH-1:0]    mask;
  logic [MAX_PH*CW-1:0] offs;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD-1))  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  mpwm_detect #(.MAX_PH(MAX_PH), .PERIOD(PERIOD), .CW(CW), .NW(NW)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .ext_en   (ext_en),
    .strap    (ph_strap),
    .run      (run),
    .err      (err),
    .mask     (mask),
    .nph      (ph_count),
    .offs     (offs)
  );

  for (genvar g = 0; g < MAX_PH; g++) begin : g_ch
    mpwm_channel #(.PERIOD(PERIOD), .CW(CW), .TW(TRIM_W), .MAXON(MAXON)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run),
      .active (mask[g]),
      .inhibit(inhibit),
      .cnt    (cnt_q),
      .offset (offs[g*CW +: CW]),
      .cmd    (duty_cmd),
      .trim   (duty_trim[g*TRIM_W +: TRIM_W]),
      .pwm    (pwm_out[g]),
      .oe     (pwm_oe[g])
    );
  end

  assign ph_ready = run;
  assign cfg_err  = err;

  AST_NO_EARLY_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (pwm_oe != '0) |-> ph_ready);                                 // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (pwm_oe == '0 && pwm_out == '0));                 // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(PERIOD));                                         // R6
endmodule

// File: tb/mpwm_seq_tb.sv
`timescale 1ns/1ps
module mpwm_seq_tb;
  localparam int P     = 48;
  localparam int MAXON = (P * 2) / 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        supply_ok = 1'b0;
  logic        ext_en = 1'b0;
  logic [3:0]  ph_strap = 4'b0000;
  logic [5:0]  duty_cmd = '0;
  logic [15:0] duty_trim = '0;
  logic        inhibit = 1'b0;
  logic [3:0]  pwm_out;
  logic [3:0]  pwm_oe;
  logic        ph_ready;
  logic        cfg_err;
  logic [2:0]  ph_count;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int hi_c[4];
  int rise_c[4];

  always #2.5 clk = ~clk;

  mpwm_seq u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ext_en(ext_en),
    .ph_strap(ph_strap), .duty_cmd(duty_cmd), .duty_trim(duty_trim),
    .inhibit(inhibit), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
    .ph_ready(ph_ready), .cfg_err(cfg_err), .ph_count(ph_count)
  );

  function automatic int exp_w(int cmd, int trim);
    int d = cmd - trim;
    if (d < 0) d = 0;
    if (d > MAXON) d = MAXON;
    return d;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [3:0] strap);
    @(negedge clk);
    rst = 1'b1; supply_ok = 1'b0; ext_en = 1'b0; inhibit = 1'b0;
    ph_strap = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1; ext_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure();
    logic [3:0] prev = '0;
    for (int k = 0; k < 4; k++) begin hi_c[k] = 0; rise_c[k] = -1; end
    for (int i = 0; i < 2*P; i++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        if (i < P) hi_c[k] += int'(pwm_out[k]);
        if (i > 0 && rise_c[k] < 0 && pwm_out[k] && !prev[k]) rise_c[k] = i;
      end
      prev = pwm_out;
    end
  endtask

  task automatic run_case(int n, int cmd, logic [15:0] trim);
    int w0, wk, lag;
    duty_cmd = 6'(cmd); duty_trim = trim;
    repeat (2*P + 2) @(negedge clk);
    measure();
    w0 = exp_w(cmd, int'(trim[3:0]));
    for (int k = 0; k < 4; k++) begin
      wk = exp_w(cmd, int'(trim[4*k +: 4]));
      if (k < n) begin
        check("R7 width", hi_c[k], wk);
        if (k > 0 && w0 > 0 && wk > 0) begin
          lag = (rise_c[k] - rise_c[0] + P) % P;
          check("R6 lag", lag, (k * P) / n);
        end
      end else begin
        check("R11 unused quiet", hi_c[k] + int'(pwm_oe[k]), 0);
      end
    end
  endtask

  task automatic err_case(logic [3:0] strap);
    int hits = 0;
    start(strap);
    duty_cmd = 6'd20;
    check("R4 err flag", int'(cfg_err), 1);
    check("R4 not ready", int'(ph_ready), 0);
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      hits += int'(pwm_oe != 0) + int'(pwm_out != 0);
    end
    check("R4 outputs quiet", hits, 0);
  endtask

  initial begin
    int n, hits;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 oe", int'(pwm_oe), 0);
    check("R1 pwm", int'(pwm_out), 0);
    check("R1 ready", int'(ph_ready), 0);
    check("R1 err", int'(cfg_err), 0);

    rst = 1'b0; ph_strap = 4'b0000;
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (10) @(negedge clk);
    check("R2 ready held", int'(ph_ready), 0);
    check("R2 oe held", int'(pwm_oe), 0);
    ext_en = 1'b1;
    @(negedge clk);
    check("R3 ready at detect", int'(ph_ready), 1);
    @(negedge clk);
    check("R3 count 4", int'(ph_count), 4);
    check("R3 oe 4", int'(pwm_oe), 4'b1111);

    ph_strap = 4'b1110;
    repeat (5) @(negedge clk);
    check("R5 oe kept", int'(pwm_oe), 4'b1111);
    check("R5 count kept", int'(ph_count), 4);

    run_case(4, 20, 16'h0000);
    run_case(4, 63, 16'h0000);
    run_case(4, 30, 16'h3F02);
    run_case(4, 3, 16'h5000);
    for (int r = 0; r < 5; r++) run_case(4, int'($urandom % 64), 16'($urandom));

    // R9 directed: change command in the middle of phase 0's pulse
    duty_cmd = 6'd30; duty_trim = '0;
    repeat (2*P) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    while (pwm_out[0]) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    duty_cmd = 6'd5;
    n = 0;
    while (pwm_out[0]) begin n++; @(negedge clk); end
    check("R9 current pulse kept", n, 30);
    while (!pwm_out[0]) @(negedge clk);
    n = 0;
    while (pwm_out[0]) begin n++; @(negedge clk); end
    check("R9 next pulse new", n, 5);

    // R10 inhibit
    duty_cmd = 6'd25;
    repeat (2*P) @(negedge clk);
    inhibit = 1'b1;
    hits = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      hits += int'(pwm_out != 0);
    end
    check("R10 outputs low", hits, 0);
    check("R10 oe kept", int'(pwm_oe), 4'b1111);
    inhibit = 1'b0;

    start(4'b1000);
    check("R3 count 3", int'(ph_count), 3);
    check("R11 oe 3", int'(pwm_oe), 4'b0111);
    run_case(3, 24, 16'h0000);
    for (int r = 0; r < 4; r++) run_case(3, int'($urandom % 64), 16'($urandom));

    start(4'b1100);
    check("R3 count 2", int'(ph_count), 2);
    check("R11 oe 2", int'(pwm_oe), 4'b0011);
    run_case(2, 40, 16'h0004);
    for (int r = 0; r < 4; r++) run_case(2, int'($urandom % 64), 16'($urandom));

    err_case(4'b1010);
    err_case(4'b1110);
    err_case(4'b0001);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule